// File: doc/BRIEF.md
# Comparator-Based ADC Control

This block is the digital side of a compare-style analog-to-digital facility. Software writes an 8-bit reference word that drives an external DAC, chooses which of four analog inputs feeds the comparator, and launches one comparison. The block holds its start bit for a fixed settle time so the DAC and the input multiplexer can settle. It then samples the comparator and latches whether the analog input lies above the reference. Software can run its own search loop on top of this single-step primitive.

The reference word is split as two nibbles over two 8-bit registers. The control register carries the channel code, the start bit, the upper nibble and the read-only result. The auxiliary register carries the lower nibble and a continuous comparator mode. In that mode the result follows the synchronized comparator input on every clock, and no start is needed. The comparator output is asynchronous and passes through a synchronizer chain before use.

Top module: `cmpadc_ctrl`

## Requirements
- R1: After reset both registers read 00h, the result bit is 0, `dac_word` is 00h and the channel code is 00.
- R2: Control register (address 0) layout: bit 7 result (read-only, writes to it are ignored), bits 6:5 channel code, bit 4 start, bits 3:0 upper nibble of the reference. Channel and nibble read back as written.
- R3: Auxiliary register (address 1) layout: bit 4 continuous mode enable, bits 3:0 lower nibble of the reference, bits 7:5 always read 0 whatever is written.
- R4: `dac_word` equals {control[3:0], auxiliary[3:0]} from the clock edge that completes the write.
- R5: `mux_sel` is one-hot: code 00 selects bit 3, 01 selects bit 0, 10 selects bit 1, 11 selects bit 2.
- R6: Writing 1 to control bit 4 starts a comparison and the bit reads 1 until it completes. Writing 0 to it does not abort a running comparison.
- R7: A comparison completes SETTLE_CYCLES clock edges after the write that started it. On that edge the result takes the synchronized comparator value (1 = input above reference) and the start bit clears.
- R8: Any register write while a comparison runs restarts the full settle count from that write.
- R9: With continuous mode on, the result loads the synchronized comparator value on every edge. The comparator input is delayed by SYNC_STAGES flops before that load.
- R10: With continuous mode off and no comparison completing, the result holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 control, 1 auxiliary |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register (combinational) |
| cmp_in | input | 1 | Asynchronous comparator output, 1 when input above reference |
| dac_word | output | 8 | Reference word driven to the DAC |
| mux_sel | output | 4 | One-hot analog input select |

## Verification
Register fields, `dac_word` and `mux_sel` are due one edge after a write. A launched result is due SETTLE_CYCLES edges after the start write, or after the last write that restarted it. In continuous mode the result lags `cmp_in` by SYNC_STAGES+1 edges. The bench model advances on each rising edge with the inputs held since the previous one. It keeps the comparator history in a queue as deep as the synchronizer. Outputs are compared at the falling edge, so every result is checked in the exact cycle it is due.

// File: rtl/cmpadc_pkg.sv
package cmpadc_pkg;
    localparam int REG_W  = 8;
    localparam int NIB_W  = 4;
    localparam int CH_W   = 2;
    localparam int NUM_CH = 1 << CH_W;

    // bit positions software relies on
    localparam int POS_RESULT = 7;
    localparam int POS_CHAN   = 5;
    localparam int POS_START  = 4;
    localparam int POS_MODE   = 4;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_AUX  = 1'b1;

    typedef struct packed {
        logic [CH_W-1:0]  chan;
        logic [NIB_W-1:0] ref_hi;
        logic [NIB_W-1:0] ref_lo;
        logic             cont_en;
        logic             start;
        logic             result;
    } regs_t;
endpackage

// File: rtl/cmpadc_sync.sv
module cmpadc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] st_d, st_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_comb st_d[g] = async_in;
        end else begin : g_next
            always_comb st_d[g] = st_q[g-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q[STAGES-1];
endmodule

// File: rtl/cmpadc_chan_dec.sv
module cmpadc_chan_dec
    import cmpadc_pkg::*;
(
    input  logic [CH_W-1:0]   chan,
    output logic [NUM_CH-1:0] mux_sel
);
    // input i is reached by code (i+1) mod NUM_CH
    for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
        localparam logic [CH_W-1:0] CODE = CH_W'((i + 1) % NUM_CH);
        always_comb mux_sel[i] = (chan == CODE);
    end
endmodule

// File: rtl/cmpadc_settle.sv
module cmpadc_settle #(
    parameter int SETTLE_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic fire
);
    localparam int CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LIM = CNT_W'(SETTLE_CYCLES - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        fire  = run && !restart && (cnt_q == LIM);
        cnt_d = cnt_q;
        if (!run || restart || fire) cnt_d = '0;
        else                         cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R7
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIM);
endmodule

// File: rtl/cmpadc_regs.sv
module cmpadc_regs
    import cmpadc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             addr,
    input  logic [REG_W-1:0] wdata,
    input  logic             fire,
    input  logic             cmp_s,
    output regs_t            regs
);
    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (fire) begin
            r_d.result = cmp_s;
            r_d.start  = 1'b0;
        end
        if (r_q.cont_en) r_d.result = cmp_s;
        if (wr_en) begin
            if (addr == ADDR_CTRL) begin
                r_d.chan   = wdata[POS_CHAN +: CH_W];
                r_d.ref_hi = wdata[NIB_W-1:0];
                if (wdata[POS_START]) r_d.start = 1'b1;
            end else begin
                r_d.cont_en = wdata[POS_MODE];
                r_d.ref_lo  = wdata[NIB_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign regs = r_q;

    // R6
    start_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.start) |-> $past(fire));
    // R8
    restart_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && r_q.start) |=> r_q.start);
    // R9
    cont_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cont_en |=> (r_q.result == $past(cmp_s)));
    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.cont_en && !fire) |=> $stable(r_q.result));
endmodule

// File: rtl/cmpadc_ctrl.sv
module cmpadc_ctrl
    import cmpadc_pkg::*;
#(
    parameter int SETTLE_CYCLES = 8,
    parameter int SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic              cmp_in,
    output logic [REG_W-1:0]  dac_word,
    output logic [NUM_CH-1:0] mux_sel
);
    regs_t regs;
    logic  cmp_s;
    logic  fire;

    cmpadc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(cmp_in), .sync_out(cmp_s)
    );

    cmpadc_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
        .clk(clk), .rst_n(rst_n), .run(regs.start), .restart(wr_en), .fire(fire)
    );

    cmpadc_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .fire(fire), .cmp_s(cmp_s), .regs(regs)
    );

    cmpadc_chan_dec u_dec (
        .chan(regs.chan), .mux_sel(mux_sel)
    );

    always_comb begin
        if (addr == ADDR_CTRL)
            rdata = {regs.result, regs.chan, regs.start, regs.ref_hi};
        else
            rdata = {3'b000, regs.cont_en, regs.ref_lo};
        dac_word = {regs.ref_hi, regs.ref_lo};
    end

    // R5
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mux_sel) == 1);
endmodule

// File: tb/cmpadc_ctrl_tb.sv
`timescale 1ns/1ps
module cmpadc_ctrl_tb;
    localparam int SETTLE = 8;
    localparam int SYNC   = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       cmp_in = 1'b0;
    logic [7:0] dac_word;
    logic [3:0] mux_sel;

    int n_chk = 0;
    int n_bad = 0;

    // behavioural model
    int m_chan, m_hi, m_lo, m_rem;
    bit m_cont, m_busy, m_res;
    bit sq[$];

    always #2 clk = ~clk;

    cmpadc_ctrl #(.SETTLE_CYCLES(SETTLE), .SYNC_STAGES(SYNC)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .cmp_in(cmp_in), .dac_word(dac_word), .mux_sel(mux_sel)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_chan = 0; m_hi = 0; m_lo = 0; m_rem = 0;
        m_cont = 0; m_busy = 0; m_res = 0;
        sq.delete();
        for (int i = 0; i < SYNC; i++) sq.push_back(1'b0);
    endtask

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else begin
            bit old_s;
            bit old_cont;
            old_s = sq[0];
            old_cont = m_cont;
            void'(sq.pop_front());
            sq.push_back(cmp_in);
            if (wr_en) begin
                if (addr == 1'b0) begin
                    m_chan = int'(wdata[6:5]);
                    m_hi   = int'(wdata[3:0]);
                    if (wdata[4] || m_busy) begin m_busy = 1; m_rem = SETTLE; end
                end else begin
                    m_cont = wdata[4];
                    m_lo   = int'(wdata[3:0]);
                    if (m_busy) m_rem = SETTLE;
                end
            end else if (m_busy) begin
                m_rem--;
                if (m_rem == 0) begin m_busy = 0; m_res = old_s; end
            end
            if (old_cont) m_res = old_s;
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic [3:0] em;
            case (m_chan)
                0: em = 4'b1000;
                1: em = 4'b0001;
                2: em = 4'b0010;
                default: em = 4'b0100;
            endcase
            check("R4", dac_word, 8'(m_hi * 16 + m_lo));
            check("R5", {4'h0, mux_sel}, {4'h0, em});
            if (addr == 1'b0) begin
                check(m_cont ? "R9" : "R7", {7'h0, rdata[7]}, {7'h0, m_res});
                check("R6", {7'h0, rdata[4]}, {7'h0, m_busy});
                check("R2", {1'b0, rdata[6:5], 1'b0, rdata[3:0]},
                      {1'b0, 2'(m_chan), 1'b0, 4'(m_hi)});
            end else begin
                check("R3", rdata, {3'b000, m_cont, 4'(m_lo)});
            end
        end
    end

    task automatic wr(input logic a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk); #1;
            cmp_in = 1'($urandom() % 2);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic saved;
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        addr = 1'b0; #1; check("R1", rdata, 8'h00);
        addr = 1'b1; #1; check("R1", rdata, 8'h00);
        check("R1", dac_word, 8'h00);
        check("R1", {4'h0, mux_sel}, 8'h08);
        rst_n = 1'b1;
        idle(2);

        // R2 / R3 / R4 layout, reserved bits written as ones
        wr(1'b0, 8'b0_01_0_1100);
        wr(1'b1, 8'hE3);
        @(negedge clk); check("R3", rdata, 8'h03);
        check("R4", dac_word, 8'hC3);
        @(posedge clk); #1;

        // R7 single comparison with the comparator high
        cmp_in = 1'b1;
        idle(4);
        wr(1'b0, 8'b0_10_1_0101);
        repeat (SETTLE + 2) begin @(posedge clk); #1; end
        addr = 1'b0; #1;
        check("R7", {7'h0, rdata[7]}, 8'h01);

        // R8 restart by a write while running; R6 writing 0 does not abort
        cmp_in = 1'b0;
        wr(1'b0, 8'b0_11_1_0110);
        idle(3);
        wr(1'b1, 8'h05);
        repeat (SETTLE - 4) begin @(posedge clk); #1; end
        addr = 1'b0;
        @(negedge clk); check("R8", {7'h0, rdata[4]}, 8'h01);
        @(posedge clk); #1;
        wr(1'b0, 8'b0_11_0_0110);
        @(negedge clk); check("R6", {7'h0, rdata[4]}, 8'h01);
        @(posedge clk); #1;
        idle(SETTLE + 3);

        // every channel code, random comparator data
        for (int c = 0; c < 4; c++) begin
            wr(1'b0, 8'(c * 32 + 16 + c));
            idle(c + 1);
            wr(1'b1, 8'(c * 3));
            idle(SETTLE + 2);
        end

        // R9 continuous mode
        wr(1'b1, 8'h1A);
        addr = 1'b0;
        idle(40);
        wr(1'b1, 8'h0A);
        addr = 1'b0;
        idle(SYNC + 2);

        // R10 result holds with continuous mode off and nothing running
        @(negedge clk); saved = rdata[7];
        @(posedge clk); #1;
        idle(12);
        @(negedge clk); check("R10", {7'h0, rdata[7]}, {7'h0, saved});
        @(posedge clk); #1;

        // R2 writes to the result bit are ignored
        wr(1'b0, {~saved, 7'b00_0_0001});
        @(negedge clk); check("R2", {7'h0, rdata[7]}, {7'h0, saved});
        @(posedge clk); #1;
        idle(5);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule